// File: doc/BRIEF.md
# Output Fault and Power-Good Monitor

This block supervises one regulated converter output. It receives three digitized window-comparator flags (output above +10 % of its set point, output below −10 %, output below −30 %), a soft-start-done flag, a startup blanking flag and the channel enable. Each condition is filtered by a consecutive-cycle deglitch counter. A qualified over-voltage condition latches a fault that asks the switching controller to hold the low-side switch on. A qualified deep under-voltage condition latches a fault that asks it to tristate both gate drivers. Both faults stay latched until the enable is taken low.

The block also drives an open-drain power-good output. Power-good is held low while the channel is disabled, during startup until soft-start is done with the output inside the window, while a window excursion has been qualified, and while any fault is latched. A dual-output supply places one instance per channel. The instances share no state, so a fault in one channel leaves the other running.

Top module: `pwr_fault_mon`

## Requirements
- R1: With the enable high, an over flag held for DG_CYC consecutive clock edges qualifies on the last of them, and `lowside_hold_o` goes to 1 after the following edge.
- R2: With the enable high and blanking low, a deep-under flag held for DG_CYC consecutive edges qualifies, and `drv_off_o` goes to 1 after the following edge.
- R3: A condition that drops before DG_CYC consecutive edges have passed has no effect, and its count restarts from zero. A later run of DG_CYC−1 edges therefore still has no effect.
- R4: A latched fault stays set while the enable stays high, even after all flags clear.
- R5: While `blank_i` is 1, the deep-under flag is ignored and no under-voltage fault latches. Over-voltage detection and its fault are unaffected by blanking.
- R6: If both faults would latch on the same edge, the over-voltage fault wins. `lowside_hold_o` and `drv_off_o` are never both 1, and once either fault is latched the other cannot latch.
- R7: After the enable rises, `pg_pull_low_o` stays 1 until an edge samples `ss_done_i` = 1 with neither the over flag nor the under-10 % flag set. It goes to 0 after that edge, unless one of the other hold-low conditions (R8, R9) is active.
- R8: An over or under-10 % flag held for DG_CYC consecutive edges sets `pg_pull_low_o` to 1 after the last of them. When both flags clear, power-good is released after the next edge.
- R9: While either fault is latched, `pg_pull_low_o` is 1.
- R10: Reset, or an edge that samples the enable low, clears both faults and the startup state. It also restarts all counters, and `pg_pull_low_o` is then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable; a low level clears latched faults |
| ov_flag_i | input | 1 | Output above +10 % of the set point |
| uv10_flag_i | input | 1 | Output below −10 % of the set point |
| uv30_flag_i | input | 1 | Output below −30 % of the set point |
| ss_done_i | input | 1 | Soft-start has finished |
| blank_i | input | 1 | Startup blanking; masks under-voltage fault detection |
| lowside_hold_o | output | 1 | Request: keep the low-side switch on (over-voltage fault) |
| drv_off_o | output | 1 | Request: tristate both drivers (under-voltage fault) |
| pg_pull_low_o | output | 1 | 1 turns on the open-drain power-good pull-down |

## Verification
The bench builds the block with DG_CYC = 8 instead of the default 200, which is 2 µs at 100 MHz. With 8, runs of exactly DG_CYC−1 and DG_CYC edges, a restarted count, and sequences that latch a fault, clear it and latch it again all fit in a few hundred cycles. The exact qualification edge and the extra latch edge can then be checked on every path. The short setting also makes simultaneous over/under qualification, blanking over a long deep-under run, and release of power-good one edge after re-entering the window cheap to reach.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_OV   = 2'd1,
    FLT_UV   = 2'd2
  } flt_e;

  localparam int unsigned IDX_OV  = 0;
  localparam int unsigned IDX_UV  = 1;
  localparam int unsigned IDX_WIN = 2;
  localparam int unsigned N_COND  = 3;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Over-voltage has priority; an existing fault blocks the other one.
  function automatic flt_e next_fault(input flt_e cur, input logic ov_q,
                                      input logic uv_q);
    if (cur != FLT_NONE) return cur;
    if (ov_q)            return FLT_OV;
    if (uv_q)            return FLT_UV;
    return FLT_NONE;
  endfunction

endpackage

// File: rtl/pfm_deglitch.sv
module pfm_deglitch #(
  parameter int unsigned DG_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic qual_o
);
  localparam int unsigned CW = pfm_pkg::cnt_width(DG_CYC);
  localparam logic [CW-1:0] LAST = CW'(DG_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      qual_o <= 1'b0;
    end else if (!cond_i) begin
      cnt_q  <= '0;
      qual_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      qual_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pfm_fault_latch.sv
module pfm_fault_latch
  import pfm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ov_qual_i,
  input  logic uv_qual_i,
  output logic lowside_hold_o,
  output logic drv_off_o
);
  flt_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= FLT_NONE;
    else if (!en_i)  state_q <= FLT_NONE;
    else             state_q <= next_fault(state_q, ov_qual_i, uv_qual_i);
  end

  assign lowside_hold_o = (state_q == FLT_OV);
  assign drv_off_o      = (state_q == FLT_UV);
endmodule

// File: rtl/pfm_pgood.sv
module pfm_pgood (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ss_done_i,
  input  logic in_window_i,
  input  logic win_qual_i,
  input  logic fault_i,
  output logic pg_pull_low_o
);
  logic started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     started_q <= 1'b0;
    else if (!en_i) started_q <= 1'b0;
    else if (ss_done_i && in_window_i) started_q <= 1'b1;
  end

  assign pg_pull_low_o = !started_q || win_qual_i || fault_i;
endmodule

// File: rtl/pwr_fault_mon.sv
module pwr_fault_mon #(
  parameter int unsigned DG_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ov_flag_i,
  input  logic uv10_flag_i,
  input  logic uv30_flag_i,
  input  logic ss_done_i,
  input  logic blank_i,
  output logic lowside_hold_o,
  output logic drv_off_o,
  output logic pg_pull_low_o
);
  import pfm_pkg::*;

  logic [N_COND-1:0] cond;
  logic [N_COND-1:0] qual;
  logic ov_qual, uv_qual, win_qual, in_window;

  assign in_window     = !ov_flag_i && !uv10_flag_i;
  assign cond[IDX_OV]  = en_i && ov_flag_i;
  assign cond[IDX_UV]  = en_i && uv30_flag_i && !blank_i;
  assign cond[IDX_WIN] = en_i && !in_window;

  for (genvar i = 0; i < N_COND; i++) begin : g_dg
    pfm_deglitch #(.DG_CYC(DG_CYC)) u_dg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (cond[i]),
      .qual_o (qual[i])
    );
  end

  assign ov_qual  = qual[IDX_OV];
  assign uv_qual  = qual[IDX_UV];
  assign win_qual = qual[IDX_WIN];

  pfm_fault_latch u_latch (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_i           (en_i),
    .ov_qual_i      (ov_qual),
    .uv_qual_i      (uv_qual),
    .lowside_hold_o (lowside_hold_o),
    .drv_off_o      (drv_off_o)
  );

  pfm_pgood u_pg (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .ss_done_i     (ss_done_i),
    .in_window_i   (in_window),
    .win_qual_i    (win_qual),
    .fault_i       (lowside_hold_o || drv_off_o),
    .pg_pull_low_o (pg_pull_low_o)
  );
endmodule

// File: rtl/pfm_checker.sv
module pfm_checker (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic ov_qual,
  input logic uv_qual,
  input logic win_qual,
  input logic lowside_hold_o,
  input logic drv_off_o,
  input logic pg_pull_low_o
);
  a_r1_ov_latches: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && ov_qual && !drv_off_o |=> lowside_hold_o);

  a_r2_uv_latches: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && uv_qual && !ov_qual && !lowside_hold_o |=> drv_off_o);

  a_r4_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && lowside_hold_o |=> lowside_hold_o);

  a_r4_uv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && drv_off_o |=> drv_off_o);

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lowside_hold_o, drv_off_o}));

  a_r8_window_pg: assert property (@(posedge clk) disable iff (!rst_n)
    win_qual |-> pg_pull_low_o);

  a_r9_fault_pg: assert property (@(posedge clk) disable iff (!rst_n)
    lowside_hold_o || drv_off_o |-> pg_pull_low_o);

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !lowside_hold_o && !drv_off_o && pg_pull_low_o);
endmodule

bind pwr_fault_mon pfm_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .en_i           (en_i),
  .ov_qual        (ov_qual),
  .uv_qual        (uv_qual),
  .win_qual       (win_qual),
  .lowside_hold_o (lowside_hold_o),
  .drv_off_o      (drv_off_o),
  .pg_pull_low_o  (pg_pull_low_o)
);

// File: tb/tb_pwr_fault_mon.sv
`timescale 1ns/1ps
module tb_pwr_fault_mon;
  localparam int unsigned N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ov = 1'b0, u10 = 1'b0, u30 = 1'b0, ss = 1'b0, bl = 1'b0;
  logic lh, off, pgl;

  typedef struct {
    logic  lh;
    logic  off;
    logic  pgl;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pwr_fault_mon #(.DG_CYC(N)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .ov_flag_i(ov), .uv10_flag_i(u10),
    .uv30_flag_i(u30), .ss_done_i(ss), .blank_i(bl),
    .lowside_hold_o(lh), .drv_off_o(off), .pg_pull_low_o(pgl)
  );

  // Monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (lh !== e.lh || off !== e.off || pgl !== e.pgl) begin
          n_fail++;
          $display("FAIL %s: got hold=%b off=%b pglow=%b exp hold=%b off=%b pglow=%b",
                   e.tag, lh, off, pgl, e.lh, e.off, e.pgl);
        end
      end
    end
  end

  task automatic drive(input logic e_, input logic o_, input logic a_,
                       input logic b_, input logic s_, input logic k_);
    en = e_; ov = o_; u10 = a_; u30 = b_; ss = s_; bl = k_;
  endtask

  // Driver: let n rising edges pass, queue the expectation, return at the falling edge.
  task automatic step_expect(input int n, input logic x_lh, input logic x_off,
                             input logic x_pgl, input string tag);
    exp_t e;
    repeat (n) @(posedge clk);
    e.lh = x_lh; e.off = x_off; e.pgl = x_pgl; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step_expect(1, 0, 0, 1, "R10 reset state");

    drive(1, 0, 0, 0, 0, 1);
    step_expect(3, 0, 0, 1, "R7 low before soft-start done");
    drive(1, 1, 0, 0, 1, 1);
    step_expect(3, 0, 0, 1, "R7 low while outside window");
    drive(1, 0, 0, 0, 1, 1);
    step_expect(1, 0, 0, 0, "R7 released after startup");

    drive(1, 1, 0, 0, 1, 1);
    step_expect(N-1, 0, 0, 0, "R3 short over run ignored");
    drive(1, 0, 0, 0, 1, 1);
    step_expect(1, 0, 0, 0, "R3 after short run");
    drive(1, 1, 0, 0, 1, 1);
    step_expect(N-1, 0, 0, 0, "R3 count restarted");
    drive(1, 0, 0, 0, 1, 1);
    step_expect(1, 0, 0, 0, "R3 no fault");

    drive(1, 0, 1, 0, 1, 1);
    step_expect(N-1, 0, 0, 0, "R8 pg still high before qualify");
    step_expect(1, 0, 0, 1, "R8 pg low on qualify");
    drive(1, 0, 0, 0, 1, 1);
    step_expect(1, 0, 0, 0, "R8 pg released in window");

    drive(1, 0, 1, 1, 1, 1);
    step_expect(N+4, 0, 0, 1, "R5 deep under blanked");
    drive(1, 0, 1, 1, 1, 0);
    step_expect(N, 0, 0, 1, "R2 not yet latched");
    step_expect(1, 0, 1, 1, "R2 drivers off latched");

    drive(1, 0, 0, 0, 1, 0);
    step_expect(3, 0, 1, 1, "R4 uv fault held, R9 pg low");
    drive(1, 1, 0, 0, 1, 0);
    step_expect(N+3, 0, 1, 1, "R6 ov cannot join uv fault");

    drive(0, 0, 0, 0, 1, 0);
    step_expect(1, 0, 0, 1, "R10 disable clears");
    drive(1, 0, 0, 0, 1, 0);
    step_expect(1, 0, 0, 0, "R7 re-start after enable");

    drive(1, 1, 0, 0, 1, 0);
    step_expect(N, 0, 0, 1, "R1 qualified, not yet latched");
    step_expect(1, 1, 0, 1, "R1 low-side hold latched");
    drive(1, 0, 0, 0, 1, 0);
    step_expect(3, 1, 0, 1, "R4 ov fault held");
    drive(0, 0, 0, 0, 1, 0);
    step_expect(1, 0, 0, 1, "R10 ov cleared by disable");

    drive(1, 0, 0, 0, 1, 0);
    step_expect(1, 0, 0, 0, "R7 in window again");
    drive(1, 1, 1, 1, 1, 0);
    step_expect(N+1, 1, 0, 1, "R6 ov wins simultaneous");
    step_expect(4, 1, 0, 1, "R6 uv never latches");
    drive(0, 0, 0, 0, 1, 0);
    step_expect(1, 0, 0, 1, "R10 clear");

    drive(1, 1, 0, 0, 1, 1);
    step_expect(N+1, 1, 0, 1, "R5 ov active during blanking");

    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog: got timeout exp completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule